// File: doc/BRIEF.md
# Sparse Address Space Translator

This block turns host accesses into single transfers on a 32-bit peripheral bus. The host bus is 64 bits wide. Two host windows are sparse. In a sparse window the peripheral address sits five bits up inside the host address, and the two bits just below it give the transfer size. The block recovers the peripheral address from that encoding. It builds byte enables from the size and from the lane the address points to. For writes it moves the host's right-aligned data onto that lane. For reads it moves the returned lane back down to bit 0.

The sparse memory window carries only 27 address bits. The top three peripheral address bits come from a high-address-extension register held in a small register bank. The host reaches that bank through its own window on the same bus. A quadword access becomes two longword transfers. Accesses that land outside the translated windows complete at once, flagged as a decode miss. Illegal size and lane combinations complete at once, flagged as an error.

The host side uses a valid/ready request and a one-cycle response pulse. The peripheral side uses a valid/ready request and a read-data strobe.

Top module: `sparse_xlate`

## Requirements
- R1: Only three host windows are translated: sparse memory (0x2_0000_0000 to 0x2_FFFF_FFFF), sparse I/O (0x3_A000_0000 to 0x3_BFFF_FFFF) and the register window (0x3_8E00_0000 to 0x3_8E00_00FF). Every other address completes with rsp_miss set and issues no peripheral request. This includes dense space at 0x3_C000_0000 and configuration space at 0x3_9000_0000.
- R2: In sparse I/O the peripheral address is the window offset shifted right by 5, and its upper 8 bits are zero.
- R3: In sparse memory, peripheral address bits 26:0 are offset bits 31:5 and bits 28:27 are zero. Bits 31:29 are copied from bits 31:29 of the extension register (register index 7, host offset 0xE0), using the value the register holds when the access is accepted.
- R4: Host address bits 4:3 select the size. 00 is a byte with enable 1<<lane. 01 is a 16-bit word with enable 3<<lane. 11 is a longword with enable 1111 and peripheral address bits 1:0 driven as 00. The lane is the recovered peripheral address bits 1:0, which are host bits 6:5.
- R5: Write data for a byte or word access is taken from h_wdata bits 7:0 or 15:0 and placed at bit 8*lane of p_wdata. A longword write sends h_wdata bits 31:0 unchanged.
- R6: Read data for a byte or word access is taken from bit 8*lane of p_rdata and returned zero-extended in rsp_data. A longword read returns p_rdata zero-extended.
- R7: Size code 10, a word at lane 3, or a quadword request whose size is not 11 completes with rsp_err set and issues no peripheral request.
- R8: A quadword request (h_quad with size 11) issues two longword transfers. The first goes to address A with h_wdata bits 31:0. The second goes to A+4 with bits 63:32. A quadword read returns {second, first} only after both read strobes.
- R9: A host write in the register window stores h_wdata bits 31:0 into register (address bits 7:5). A read returns that register zero-extended. All registers reset to zero. Neither touches the peripheral bus.
- R10: h_ready is high only while no access is in flight. Each peripheral request holds p_valid with stable address, enables and data until p_ready. A read response is given only after p_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Block can accept a host request |
| h_write | input | 1 | Host request is a write |
| h_quad | input | 1 | Host request is a 64-bit quadword |
| h_addr | input | 36 | Host address |
| h_wdata | input | 64 | Host write data, right-aligned |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 64 | Read data, right-aligned |
| rsp_err | output | 1 | Completion carries an encoding error |
| rsp_miss | output | 1 | Completion carries a decode miss |
| p_valid | output | 1 | Peripheral request valid |
| p_ready | input | 1 | Peripheral accepts request |
| p_write | output | 1 | Peripheral request is a write |
| p_addr | output | 32 | Peripheral byte address |
| p_be | output | 4 | Peripheral byte enables |
| p_wdata | output | 32 | Peripheral write data on its lanes |
| p_rvalid | input | 1 | Peripheral read data strobe |
| p_rdata | input | 32 | Peripheral read data |

## Verification
The bench covers the following corner cases:
- **Lane 3 word and size code 10.** A design that let these through would show a peripheral request with a wrapped or empty enable.
- **Extension bits after a register write.** A design that ignored the register, or placed its bits wrongly, would send sparse memory traffic to the wrong upper address.
- **Quadword reads with read data held back for several cycles.** A design that answered early, or swapped the halves, would give a response before the second strobe, or the wrong 64-bit word.
- **Addresses just outside each window.** This covers dense, configuration and the register window above its last register. A loose decoder would translate these instead of flagging a miss.

// File: rtl/sx_pkg.sv
package sx_pkg;

   typedef enum logic [1:0] {
      LEN_BYTE = 2'b00,
      LEN_WORD = 2'b01,
      LEN_BAD  = 2'b10,
      LEN_LONG = 2'b11
   } sx_len_e;

   typedef enum logic [1:0] {
      RGN_MISS = 2'd0,
      RGN_SMEM = 2'd1,
      RGN_SIO  = 2'd2,
      RGN_CSR  = 2'd3
   } sx_rgn_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RESP  = 2'd3
   } sx_state_e;

endpackage

// File: rtl/sx_decode.sv
module sx_decode
   import sx_pkg::*;
#(
   parameter int HA_W = 36,
   parameter int PA_W = 32,
   parameter int SHIFT = 5,
   parameter logic [HA_W-1:0] SMEM_BASE = 36'h2_0000_0000,
   parameter int SMEM_SPAN_LG = 32,
   parameter logic [HA_W-1:0] SIO_BASE = 36'h3_A000_0000,
   parameter int SIO_SPAN_LG = 29,
   parameter logic [HA_W-1:0] CSR_BASE = 36'h3_8E00_0000,
   parameter int CSR_N = 8,
   parameter int HAE_BITS = 3,
   parameter int LANE_W = 2
) (
   input  logic [HA_W-1:0]          addr_i,
   input  logic                     quad_i,
   input  logic [HAE_BITS-1:0]      hae_i,
   output sx_rgn_e                  rgn_o,
   output sx_len_e                  len_o,
   output logic [LANE_W-1:0]        lane_o,
   output logic [PA_W-1:0]          pci_o,
   output logic                     bad_o,
   output logic [$clog2(CSR_N)-1:0] csr_idx_o
);

   localparam int SMEM_LOW_W  = SMEM_SPAN_LG - SHIFT;
   localparam int SIO_LOW_W   = SIO_SPAN_LG - SHIFT;
   localparam int CSR_IDX_W   = $clog2(CSR_N);
   localparam int CSR_SPAN_LG = SHIFT + CSR_IDX_W;

   if (SMEM_LOW_W + HAE_BITS > PA_W) begin : g_chk_smem
      $error("sx_decode: sparse memory offset plus extension exceeds address width");
   end
   if (SIO_LOW_W > PA_W) begin : g_chk_sio
      $error("sx_decode: sparse I/O offset exceeds address width");
   end
   if (CSR_SPAN_LG >= HA_W || SMEM_SPAN_LG >= HA_W || SIO_SPAN_LG >= HA_W) begin : g_chk_span
      $error("sx_decode: window span not below host address width");
   end
   if (SHIFT < 4) begin : g_chk_shift
      $error("sx_decode: shift must leave room for the size field");
   end

   logic smem_hit, sio_hit, csr_hit;
   logic [PA_W-1:0] raw_pci;

   assign smem_hit = (addr_i[HA_W-1:SMEM_SPAN_LG] == SMEM_BASE[HA_W-1:SMEM_SPAN_LG]);
   assign sio_hit  = (addr_i[HA_W-1:SIO_SPAN_LG]  == SIO_BASE[HA_W-1:SIO_SPAN_LG]);
   assign csr_hit  = (addr_i[HA_W-1:CSR_SPAN_LG]  == CSR_BASE[HA_W-1:CSR_SPAN_LG]);

   always_comb begin
      rgn_o = RGN_MISS;
      if (smem_hit)     rgn_o = RGN_SMEM;
      else if (sio_hit) rgn_o = RGN_SIO;
      else if (csr_hit) rgn_o = RGN_CSR;
   end

   assign len_o = sx_len_e'(addr_i[SHIFT-1:SHIFT-2]);

   always_comb begin
      raw_pci = '0;
      if (rgn_o == RGN_SMEM) begin
         raw_pci[SMEM_LOW_W-1:0]       = addr_i[SMEM_SPAN_LG-1:SHIFT];
         raw_pci[PA_W-1 -: HAE_BITS]   = hae_i;
      end else begin
         raw_pci[SIO_LOW_W-1:0]        = addr_i[SIO_SPAN_LG-1:SHIFT];
      end
   end

   assign lane_o = raw_pci[LANE_W-1:0];

   always_comb begin
      pci_o = raw_pci;
      if (len_o == LEN_LONG) pci_o[LANE_W-1:0] = '0;
   end

   assign bad_o = (len_o == LEN_BAD)
               || (len_o == LEN_WORD && lane_o == '1)
               || (quad_i && len_o != LEN_LONG);

   assign csr_idx_o = addr_i[CSR_SPAN_LG-1:SHIFT];

   logic unused_low;
   assign unused_low = ^addr_i[SHIFT-3:0];

endmodule

// File: rtl/sx_lanes.sv
module sx_lanes
   import sx_pkg::*;
#(
   parameter int PD_W = 32,
   parameter int NL = PD_W / 8,
   parameter int LANE_W = $clog2(NL)
) (
   input  sx_len_e             len_i,
   input  logic [LANE_W-1:0]   lane_i,
   input  logic                hi_i,
   input  logic [2*PD_W-1:0]   wdata_i,
   input  logic [PD_W-1:0]     rdata_i,
   output logic [NL-1:0]       be_o,
   output logic [PD_W-1:0]     wdata_o,
   output logic [PD_W-1:0]     rdata_o
);

   if (PD_W % 8 != 0 || NL < 2 || (1 << LANE_W) != NL) begin : g_chk_width
      $error("sx_lanes: data width must be a power-of-two number of bytes, at least two");
   end

   logic [PD_W-1:0] src;
   logic [PD_W-1:0] shifted;
   logic            is_long, is_word;

   assign is_long = (len_i == LEN_LONG);
   assign is_word = (len_i == LEN_WORD);
   assign src     = hi_i ? wdata_i[2*PD_W-1:PD_W] : wdata_i[PD_W-1:0];

   for (genvar i = 0; i < NL; i++) begin : g_lane
      logic sel_lo, sel_hi;
      assign sel_lo = (lane_i == LANE_W'(i));
      if (i > 0) begin : g_hi
         assign sel_hi = is_word && (lane_i == LANE_W'(i - 1));
      end else begin : g_nohi
         assign sel_hi = 1'b0;
      end
      assign be_o[i] = is_long || sel_lo || sel_hi;
      assign wdata_o[8*i +: 8] = is_long ? src[8*i +: 8]
                               : sel_hi  ? src[15:8]
                               :           src[7:0];
   end

   assign shifted = rdata_i >> {lane_i, 3'b000};

   always_comb begin
      if (is_long)      rdata_o = rdata_i;
      else if (is_word) rdata_o = PD_W'(shifted[15:0]);
      else              rdata_o = PD_W'(shifted[7:0]);
   end

endmodule

// File: rtl/sx_csr.sv
module sx_csr #(
   parameter int N = 8,
   parameter int W = 32,
   parameter int HAE_IDX = 7,
   parameter int HAE_BITS = 3,
   parameter int IDX_W = $clog2(N)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_i,
   input  logic [IDX_W-1:0]    idx_i,
   input  logic [W-1:0]        wdata_i,
   output logic [W-1:0]        rdata_o,
   output logic [HAE_BITS-1:0] hae_o
);

   if ((1 << IDX_W) != N) begin : g_chk_n
      $error("sx_csr: register count must be a power of two");
   end
   if (HAE_IDX >= N || HAE_BITS > W) begin : g_chk_hae
      $error("sx_csr: extension register out of range");
   end

   logic [W-1:0] regs [N];

   for (genvar i = 0; i < N; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               regs[i] <= '0;
         else if (we_i && idx_i == IDX_W'(i))     regs[i] <= wdata_i;
      end
   end

   assign rdata_o = regs[idx_i];
   assign hae_o   = regs[HAE_IDX][W-1 -: HAE_BITS];

endmodule

// File: rtl/sparse_xlate.sv
module sparse_xlate
   import sx_pkg::*;
#(
   parameter int HA_W = 36,
   parameter int HD_W = 64,
   parameter int PA_W = 32,
   parameter int PD_W = 32,
   parameter int SHIFT = 5,
   parameter logic [HA_W-1:0] SMEM_BASE = 36'h2_0000_0000,
   parameter int SMEM_SPAN_LG = 32,
   parameter logic [HA_W-1:0] SIO_BASE = 36'h3_A000_0000,
   parameter int SIO_SPAN_LG = 29,
   parameter logic [HA_W-1:0] CSR_BASE = 36'h3_8E00_0000,
   parameter int CSR_N = 8,
   parameter int CSR_W = 32,
   parameter int HAE_IDX = 7,
   parameter int HAE_BITS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_valid,
   output logic              h_ready,
   input  logic              h_write,
   input  logic              h_quad,
   input  logic [HA_W-1:0]   h_addr,
   input  logic [HD_W-1:0]   h_wdata,
   output logic              rsp_valid,
   output logic [HD_W-1:0]   rsp_data,
   output logic              rsp_err,
   output logic              rsp_miss,
   output logic              p_valid,
   input  logic              p_ready,
   output logic              p_write,
   output logic [PA_W-1:0]   p_addr,
   output logic [PD_W/8-1:0] p_be,
   output logic [PD_W-1:0]   p_wdata,
   input  logic              p_rvalid,
   input  logic [PD_W-1:0]   p_rdata
);

   localparam int NL        = PD_W / 8;
   localparam int LANE_W    = $clog2(NL);
   localparam int CSR_IDX_W = $clog2(CSR_N);

   if (HD_W != 2 * PD_W) begin : g_chk_hd
      $error("sparse_xlate: host data must be twice the peripheral data width");
   end
   if (CSR_W > HD_W || CSR_W > PD_W * 2) begin : g_chk_csr
      $error("sparse_xlate: register width exceeds host data width");
   end

   // decode of the incoming host address
   sx_rgn_e               d_rgn;
   sx_len_e               d_len;
   logic [LANE_W-1:0]     d_lane;
   logic [PA_W-1:0]       d_pci;
   logic                  d_bad;
   logic [CSR_IDX_W-1:0]  d_idx;
   logic [HAE_BITS-1:0]   hae;
   logic [CSR_W-1:0]      csr_rdata;

   sx_decode #(
      .HA_W(HA_W), .PA_W(PA_W), .SHIFT(SHIFT),
      .SMEM_BASE(SMEM_BASE), .SMEM_SPAN_LG(SMEM_SPAN_LG),
      .SIO_BASE(SIO_BASE), .SIO_SPAN_LG(SIO_SPAN_LG),
      .CSR_BASE(CSR_BASE), .CSR_N(CSR_N),
      .HAE_BITS(HAE_BITS), .LANE_W(LANE_W)
   ) u_decode (
      .addr_i    (h_addr),
      .quad_i    (h_quad),
      .hae_i     (hae),
      .rgn_o     (d_rgn),
      .len_o     (d_len),
      .lane_o    (d_lane),
      .pci_o     (d_pci),
      .bad_o     (d_bad),
      .csr_idx_o (d_idx)
   );

   // sequencing state
   sx_state_e           st;
   logic                beat;
   logic                r_write, r_quad;
   sx_len_e             r_len;
   logic [LANE_W-1:0]   r_lane;
   logic [PA_W-1:0]     r_pci;
   logic [HD_W-1:0]     r_wdata;
   logic [PD_W-1:0]     r_lo;
   logic [HD_W-1:0]     rsp_data_q;
   logic                rsp_err_q, rsp_miss_q;
   logic                acc, csr_we;
   logic [PD_W-1:0]     lane_rdata;

   assign h_ready = (st == ST_IDLE);
   assign acc     = h_valid && h_ready;
   assign csr_we  = acc && h_write && (d_rgn == RGN_CSR);

   sx_csr #(
      .N(CSR_N), .W(CSR_W), .HAE_IDX(HAE_IDX), .HAE_BITS(HAE_BITS)
   ) u_csr (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (csr_we),
      .idx_i   (d_idx),
      .wdata_i (h_wdata[CSR_W-1:0]),
      .rdata_o (csr_rdata),
      .hae_o   (hae)
   );

   sx_lanes #(.PD_W(PD_W)) u_lanes (
      .len_i   (r_len),
      .lane_i  (r_lane),
      .hi_i    (beat),
      .wdata_i (r_wdata),
      .rdata_i (p_rdata),
      .be_o    (p_be),
      .wdata_o (p_wdata),
      .rdata_o (lane_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         beat       <= 1'b0;
         r_write    <= 1'b0;
         r_quad     <= 1'b0;
         r_len      <= LEN_BYTE;
         r_lane     <= '0;
         r_pci      <= '0;
         r_wdata    <= '0;
         r_lo       <= '0;
         rsp_data_q <= '0;
         rsp_err_q  <= 1'b0;
         rsp_miss_q <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (acc) begin
                  rsp_data_q <= '0;
                  rsp_err_q  <= 1'b0;
                  rsp_miss_q <= 1'b0;
                  beat       <= 1'b0;
                  unique case (d_rgn)
                     RGN_MISS: begin
                        rsp_miss_q <= 1'b1;
                        st         <= ST_RESP;
                     end
                     RGN_CSR: begin
                        if (!h_write) rsp_data_q <= HD_W'(csr_rdata);
                        st <= ST_RESP;
                     end
                     default: begin
                        if (d_bad) begin
                           rsp_err_q <= 1'b1;
                           st        <= ST_RESP;
                        end else begin
                           r_write <= h_write;
                           r_quad  <= h_quad;
                           r_len   <= d_len;
                           r_lane  <= d_lane;
                           r_pci   <= d_pci;
                           r_wdata <= h_wdata;
                           st      <= ST_ISSUE;
                        end
                     end
                  endcase
               end
            end
            ST_ISSUE: begin
               if (p_ready) begin
                  if (!r_write)                st   <= ST_WAIT;
                  else if (r_quad && !beat)    beat <= 1'b1;
                  else                         st   <= ST_RESP;
               end
            end
            ST_WAIT: begin
               if (p_rvalid) begin
                  if (r_quad && !beat) begin
                     r_lo <= p_rdata;
                     beat <= 1'b1;
                     st   <= ST_ISSUE;
                  end else begin
                     rsp_data_q <= r_quad ? {p_rdata, r_lo} : HD_W'(lane_rdata);
                     st         <= ST_RESP;
                  end
               end
            end
            ST_RESP: st <= ST_IDLE;
         endcase
      end
   end

   assign p_valid   = (st == ST_ISSUE);
   assign p_write   = r_write;
   assign p_addr    = r_pci + (PA_W'(beat) << LANE_W);
   assign rsp_valid = (st == ST_RESP);
   assign rsp_data  = rsp_data_q;
   assign rsp_err   = rsp_err_q;
   assign rsp_miss  = rsp_miss_q;

   AST_MISS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      acc && d_rgn == RGN_MISS |=> !p_valid && rsp_valid && rsp_miss); // R1
   AST_BAD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (d_rgn == RGN_SMEM || d_rgn == RGN_SIO) && d_bad |=> !p_valid && rsp_valid && rsp_err); // R7
   AST_LONG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      p_valid && p_be == '1 |-> p_addr[LANE_W-1:0] == '0); // R4
   AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      p_valid |-> ($countones(p_be) == 1 || $countones(p_be) == 2 || p_be == '1)); // R4
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      p_valid && !p_ready |=> p_valid && $stable(p_addr) && $stable(p_be) && $stable(p_wdata)); // R10
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid || rsp_valid) |-> !h_ready); // R10
   AST_QUAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      p_valid && p_ready && p_write && r_quad && !beat |=> p_valid && p_addr == $past(p_addr) + PA_W'(NL)); // R8

endmodule

// File: tb/sparse_xlate_bench.sv
module sparse_xlate_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_valid = 1'b0, h_write = 1'b0, h_quad = 1'b0;
   logic [35:0] h_addr = '0;
   logic [63:0] h_wdata = '0;
   logic        h_ready, rsp_valid, rsp_err, rsp_miss;
   logic [63:0] rsp_data;
   logic        p_valid, p_write;
   logic        p_ready = 1'b0, p_rvalid = 1'b0;
   logic [31:0] p_addr, p_wdata;
   logic [31:0] p_rdata = '0;
   logic [3:0]  p_be;

   always #10 clk = ~clk;

   sparse_xlate u_sparse_xlate (
      .clk(clk), .rst_n(rst_n),
      .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write), .h_quad(h_quad),
      .h_addr(h_addr), .h_wdata(h_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_miss(rsp_miss),
      .p_valid(p_valid), .p_ready(p_ready), .p_write(p_write), .p_addr(p_addr),
      .p_be(p_be), .p_wdata(p_wdata), .p_rvalid(p_rvalid), .p_rdata(p_rdata)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] csr_m [8];

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_pat(input logic [31:0] pa);
      return (pa * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   function automatic logic [35:0] mk_smem(input logic [26:0] off, input logic [1:0] len);
      return 36'h2_0000_0000 | (36'(off) << 5) | 36'({len, 3'b000});
   endfunction

   function automatic logic [35:0] mk_sio(input logic [23:0] off, input logic [1:0] len);
      return 36'h3_A000_0000 | (36'(off) << 5) | 36'({len, 3'b000});
   endfunction

   function automatic logic [35:0] mk_csr(input logic [2:0] idx);
      return 36'h3_8E00_0000 | 36'({idx, 5'b00000});
   endfunction

   task automatic access(input bit wr, input bit quad, input logic [35:0] a,
                         input logic [63:0] wd, input int rlat);
      int          kind;
      logic [1:0]  len;
      logic [1:0]  lane;
      logic [31:0] pa;
      logic [3:0]  be;
      logic [31:0] mask;
      logic [31:0] ew;
      logic [63:0] exp_d;
      logic [31:0] rdh [2];
      bit          bad;
      int          nb;
      int          t;
      string       atag;
      len  = a[4:3];
      lane = a[6:5];
      if (a[35:32] == 4'h2)          kind = 1;
      else if (a[35:29] == 7'h1D)    kind = 2;
      else if (a[35:8] == 28'h38E0000) kind = 3;
      else                           kind = 0;
      pa = (kind == 1) ? {csr_m[7][31:29], 2'b00, a[31:5]} : {8'h00, a[28:5]};
      bad = (kind == 1 || kind == 2) &&
            (len == 2'b10 || (len == 2'b01 && lane == 2'd3) || (quad && len != 2'b11));
      if (len == 2'b11) pa[1:0] = 2'b00;
      be = (len == 2'b00) ? (4'b0001 << lane) : (len == 2'b01) ? (4'b0011 << lane) : 4'b1111;
      nb = ((kind == 1 || kind == 2) && !bad) ? (quad ? 2 : 1) : 0;
      atag = (kind == 1) ? "R3 sparse memory address" : "R2 sparse I/O address";
      exp_d = '0;
      if (kind == 3) begin
         if (!wr) exp_d = {32'h0, csr_m[a[7:5]]};
         else     csr_m[a[7:5]] = wd[31:0];
      end

      @(negedge clk);
      chk(h_ready === 1'b1, "R10 ready while idle", 64'(h_ready), 64'd1);
      h_valid = 1'b1; h_write = wr; h_quad = quad; h_addr = a; h_wdata = wd;
      @(negedge clk);
      h_valid = 1'b0;

      for (int b = 0; b < nb; b++) begin
         t = 0;
         while (!p_valid && t < 30) begin @(negedge clk); t++; end
         chk(p_valid === 1'b1, "R10 request issued", 64'(p_valid), 64'd1);
         chk(p_addr === pa + 32'(4 * b), quad ? "R8 quad beat address" : atag, 64'(p_addr), 64'(pa + 32'(4 * b)));
         chk(p_be === be, "R4 byte enables", 64'(p_be), 64'(be));
         chk(p_write === wr, "R10 direction", 64'(p_write), 64'(wr));
         if (wr) begin
            mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
            if (len == 2'b00)      ew = {24'h0, wd[7:0]}  << (8 * lane);
            else if (len == 2'b01) ew = {16'h0, wd[15:0]} << (8 * lane);
            else                   ew = (b == 1) ? wd[63:32] : wd[31:0];
            chk((p_wdata & mask) === (ew & mask), quad ? "R8 quad write data" : "R5 write lane steering",
                64'(p_wdata & mask), 64'(ew & mask));
         end
         p_ready = 1'b1;
         @(negedge clk);
         p_ready = 1'b0;
         if (!wr) begin
            for (int k = 0; k < rlat; k++) begin
               chk(rsp_valid === 1'b0, "R10 no response before read data", 64'(rsp_valid), 64'd0);
               @(negedge clk);
            end
            rdh[b] = rd_pat(pa + 32'(4 * b));
            p_rvalid = 1'b1; p_rdata = rdh[b];
            @(negedge clk);
            p_rvalid = 1'b0;
         end
      end

      t = 0;
      while (!rsp_valid && t < 30) begin @(negedge clk); t++; end
      chk(rsp_valid === 1'b1, "R10 response given", 64'(rsp_valid), 64'd1);
      if (nb == 0)
         chk(p_valid === 1'b0, (kind == 0) ? "R1 no request on miss" : bad ? "R7 no request on error" : "R9 no request for register",
             64'(p_valid), 64'd0);
      chk(rsp_miss === (kind == 0), "R1 decode miss flag", 64'(rsp_miss), 64'(kind == 0));
      chk(rsp_err === bad, "R7 error flag", 64'(rsp_err), 64'(bad));
      if (!wr && nb > 0) begin
         if (quad)              exp_d = {rdh[1], rdh[0]};
         else if (len == 2'b00) exp_d = 64'((rdh[0] >> (8 * lane)) & 32'hFF);
         else if (len == 2'b01) exp_d = 64'((rdh[0] >> (8 * lane)) & 32'hFFFF);
         else                   exp_d = 64'(rdh[0]);
         chk(rsp_data === exp_d, quad ? "R8 quad read data" : "R6 read lane extraction", rsp_data, exp_d);
      end else if (!wr && kind == 3) begin
         chk(rsp_data === exp_d, "R9 register read back", rsp_data, exp_d);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [1:0]  len;
      logic [35:0] a;
      int          kind;
      bit          quad;
      for (int i = 0; i < 8; i++) csr_m[i] = '0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(h_ready === 1'b1, "R10 reset ready", 64'(h_ready), 64'd1);
      chk(p_valid === 1'b0, "R10 reset no request", 64'(p_valid), 64'd0);
      chk(rsp_valid === 1'b0, "R10 reset no response", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;

      // directed corner cases
      access(1'b0, 1'b0, mk_csr(3'd7), 64'h0, 0);                       // R9 reset value
      access(1'b1, 1'b0, mk_csr(3'd7), 64'hFFFF_FFFF_A000_0000, 0);     // R3 extension = 101
      access(1'b0, 1'b0, mk_csr(3'd7), 64'h0, 0);                       // R9 read back
      access(1'b1, 1'b0, mk_smem(27'h4ABCDE, 2'b00), 64'h0000_0000_0000_005C, 0); // R5 lane 2 byte
      access(1'b0, 1'b0, mk_smem(27'h7FFFFFF, 2'b00), 64'h0, 2);        // R6 lane 3 byte, top offset
      access(1'b1, 1'b0, mk_smem(27'h0000013, 2'b01), 64'h1234, 0);     // R7 word at lane 3
      access(1'b0, 1'b0, mk_sio(24'h000456, 2'b10), 64'h0, 0);          // R7 size code 10
      access(1'b0, 1'b1, mk_smem(27'h0000100, 2'b00), 64'h0, 0);        // R7 quad with byte size
      access(1'b0, 1'b0, mk_sio(24'hFFFFFE, 2'b01), 64'h0, 3);          // R6 word lane 2
      access(1'b1, 1'b1, mk_smem(27'h1234560, 2'b11), 64'hDEAD_BEEF_0BAD_F00D, 0); // R8 quad write
      access(1'b0, 1'b1, mk_sio(24'h00ABC4, 2'b11), 64'h0, 4);          // R8 quad read, slow data
      access(1'b0, 1'b0, 36'h3_C000_0040, 64'h0, 0);                    // R1 dense
      access(1'b1, 1'b0, 36'h3_9000_0018, 64'h55, 0);                   // R1 configuration
      access(1'b0, 1'b0, 36'h3_8E00_0100, 64'h0, 0);                    // R1 above register window
      access(1'b1, 1'b0, mk_csr(3'd7), 64'h2000_0000, 0);               // R3 extension = 001
      access(1'b0, 1'b0, mk_smem(27'h0000000, 2'b11), 64'h0, 1);        // R3 upper bits follow

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         kind = $urandom_range(0, 9);
         len  = 2'($urandom_range(0, 3));
         quad = (len == 2'b11) ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 15) == 0);
         if (kind <= 3)      a = mk_smem(27'($urandom), len);
         else if (kind <= 5) a = mk_sio(24'($urandom), len);
         else if (kind == 6) a = mk_csr(($urandom_range(0, 1) == 0) ? 3'd7 : 3'($urandom));
         else if (kind == 7) a = 36'h3_C000_0000 | 36'($urandom_range(0, 32'h0FFF_FFFF));
         else if (kind == 8) a = 36'h3_9000_0000 | 36'($urandom_range(0, 32'h0FFF_FFFF));
         else                a = {4'h0, 32'($urandom)};
         access($urandom_range(0, 1) == 1, quad, a, {32'($urandom), 32'($urandom)}, $urandom_range(0, 3));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule